// File: doc/BRIEF.md
# ADC Output Data Formatter

This block takes each 16-bit offset-binary sample from a converter core and turns it into the word that leaves the chip. Several coding options can be combined in a fixed order. First, an optional two's-complement conversion. Then a randomizer that scrambles the upper bits with the LSB. Then a polarity scheme that inverts every odd-numbered bit. Last, a group of forced test patterns that let a board check every data line without a live analog input.

The mode bits come from a register interface that is outside this block. They are sampled on the same clock edge as the sample they apply to. A single register stage drives the outputs. The output-enable flag lets the pad ring tristate the data lines and the output clock.

Top module: `adc_out_fmt`

## Requirements
- R1: While `rst_n` is low, `out_data` is 0, `out_valid` is 0, `out_en` is 0 and the pattern phase is 0.
- R2: With every mode off, a sample accepted with `in_valid` high appears unchanged on `out_data` one clock later. `out_valid` equals `in_valid` delayed by one clock.
- R3: With `twos_comp` high and `alt_pol_en` low, the sample MSB (bit 15) is inverted and all other bits pass through.
- R4: With `rand_en` high, bits 15 down to 1 are each XORed with bit 0 of the coded word, and bit 0 is unchanged.
- R5: With `alt_pol_en` high, bits 1, 3, 5, 7, 9, 11, 13 and 15 are inverted (mask 0xAAAA).
- R6: While `alt_pol_en` is high, `twos_comp` has no effect and the coding stays offset binary.
- R7: The stages apply in this order: coding conversion, then randomizer, then odd-bit inversion. Every combination of the three controls is allowed.
- R8: `pat_mode` selects the forced pattern, which overrides R3 to R5 on bits 15 down to 2:
  - 0 means no pattern;
  - 1 forces all ones;
  - 2 forces all zeros;
  - 3 selects alternating ones and zeros;
  - 4 selects checkerboard;
  - 5, 6 and 7 act as 0.
- R9: In pattern modes 1 to 4, output bits 1 and 0 carry the raw sample bits 1 and 0.
- R10: A phase bit resets to 0 and toggles on every accepted sample in every mode. The phase that applies to a sample is the value before that sample toggles it.
  - Alternating mode gives ones at phase 0 and zeros at phase 1.
  - Checkerboard gives 1010…10 on bits 15 to 2 at phase 0 (bit 15 = 1) and 0101…01 at phase 1.
- R11: When `in_valid` is low, `out_data` holds its previous value and `out_valid` is 0 on the next clock.
- R12: `out_en` equals the inverse of `out_disable`, registered by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe from the core |
| in_sample | input | 16 | Offset-binary sample |
| twos_comp | input | 1 | Two's-complement coding select |
| rand_en | input | 1 | Randomizer enable |
| alt_pol_en | input | 1 | Odd-bit inversion enable |
| pat_mode | input | 3 | Test pattern select |
| out_disable | input | 1 | Request to tristate the outputs |
| out_data | output | 16 | Formatted data word |
| out_valid | output | 1 | Output word valid |
| out_en | output | 1 | Pad output enable, high drives |

## Verification
The assertions assume that the mode inputs are steady across the edge that accepts a sample. They also assume that `in_valid` is low throughout reset. The bench changes all inputs only on falling edges and keeps the strobe low until after reset is released. It sweeps every combination of the three coding controls against all eight `pat_mode` codes. It includes extreme samples and idle gaps, so that the phase history and the hold behaviour are both exercised.

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  input  logic         twos_comp,
  input  logic         rand_en,
  input  logic         alt_pol_en,
  input  logic [2:0]   pat_mode,
  input  logic         out_disable,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  output logic         out_en
);

  localparam logic [2:0] PAT_ONES   = 3'd1;
  localparam logic [2:0] PAT_ZEROS  = 3'd2;
  localparam logic [2:0] PAT_TOGGLE = 3'd3;
  localparam logic [2:0] PAT_CHECK  = 3'd4;

  function automatic logic [W-1:0] odd_bits();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [W-1:0] ODD = odd_bits();

  logic         phase;
  logic         pat_on;
  logic [W-3:0] pat_hi;
  logic [W-1:0] coded, scrambled, polar, next_word;

  assign coded     = {in_sample[W-1] ^ (twos_comp & ~alt_pol_en), in_sample[W-2:0]};
  assign scrambled = rand_en ? {coded[W-1:1] ^ {(W-1){coded[0]}}, coded[0]} : coded;
  assign polar     = alt_pol_en ? (scrambled ^ ODD) : scrambled;

  always_comb begin
    pat_on = 1'b1;
    case (pat_mode)
      PAT_ONES:   pat_hi = '1;
      PAT_ZEROS:  pat_hi = '0;
      PAT_TOGGLE: pat_hi = phase ? '0 : '1;
      PAT_CHECK:  pat_hi = phase ? ~ODD[W-1:2] : ODD[W-1:2];
      default: begin
        pat_on = 1'b0;
        pat_hi = '0;
      end
    endcase
  end

  assign next_word = pat_on ? {pat_hi, in_sample[1:0]} : polar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_en    <= 1'b0;
      phase     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_en    <= ~out_disable;
      if (in_valid) begin
        out_data <= next_word;
        phase    <= ~phase;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R8
  ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_mode == PAT_ONES) |=> (out_data[W-1:2] == {(W-2){1'b1}}));

  // R10
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_mode == PAT_TOGGLE) |=>
      (out_data[W-1:2] == {(W-2){1'b1}} || out_data[W-1:2] == {(W-2){1'b0}}));

  // R9
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pat_mode >= PAT_ONES && pat_mode <= PAT_CHECK) |=>
      (out_data[1:0] == $past(in_sample[1:0])));

  // R12
  oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |=> !out_en);

endmodule

// File: tb/adc_out_fmt_tb.sv
`timescale 1ns/1ps
module adc_out_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        twos_comp = 1'b0, rand_en = 1'b0, alt_pol_en = 1'b0, out_disable = 1'b0;
  logic [2:0]  pat_mode = '0;
  logic [15:0] out_data;
  logic        out_valid, out_en;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic ph = 1'b0;
  logic [15:0] held = '0;

  always #2.5 clk = ~clk;

  adc_out_fmt #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .twos_comp(twos_comp), .rand_en(rand_en), .alt_pol_en(alt_pol_en),
    .pat_mode(pat_mode), .out_disable(out_disable),
    .out_data(out_data), .out_valid(out_valid), .out_en(out_en)
  );

  function automatic logic [15:0] model(logic [15:0] s, logic tc, logic rn, logic ap,
                                        logic [2:0] pm, logic p);
    logic [15:0] v;
    v = s;
    if (tc && !ap) v[15] = ~v[15];
    if (rn) for (int i = 1; i < 16; i++) v[i] = v[i] ^ v[0];
    if (ap) for (int i = 1; i < 16; i += 2) v[i] = ~v[i];
    if (pm >= 3'd1 && pm <= 3'd4) begin
      for (int i = 2; i < 16; i++) begin
        case (pm)
          3'd1: v[i] = 1'b1;
          3'd2: v[i] = 1'b0;
          3'd3: v[i] = ~p;
          default: v[i] = ((i % 2) == 1) ^ p;
        endcase
      end
      v[1:0] = s[1:0];
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [15:0] s, logic dis);
    logic [15:0] e;
    logic        prev_dis;
    in_valid = v; in_sample = s;
    prev_dis = dis; out_disable = dis;
    e = model(s, twos_comp, rand_en, alt_pol_en, pat_mode, ph);
    @(negedge clk);
    check("R2/R11 valid", {31'd0, out_valid}, {31'd0, v});
    check("R12 out_en", {31'd0, out_en}, {31'd0, ~prev_dis});
    if (v) begin
      // R3 R4 R5 R6 R7 R8 R9 R10
      check("R7 data", {16'd0, out_data}, {16'd0, e});
      held = e;
      ph = ~ph;
    end else begin
      check("R11 hold", {16'd0, out_data}, {16'd0, held});
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 data", {16'd0, out_data}, 32'd0);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 out_en", {31'd0, out_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 plain pass-through, extremes
    step(1'b1, 16'h0000, 1'b0);
    step(1'b1, 16'hFFFF, 1'b0);
    step(1'b1, 16'h8000, 1'b0);
    step(1'b0, 16'h1234, 1'b1);
    for (int cfg = 0; cfg < 64; cfg++) begin
      twos_comp  = cfg[0];
      rand_en    = cfg[1];
      alt_pol_en = cfg[2];
      pat_mode   = cfg[5:3];
      for (int j = 0; j < 24; j++) begin
        logic [15:0] s;
        case (j)
          0: s = 16'h0000;
          1: s = 16'hFFFF;
          2: s = 16'h8000;
          3: s = 16'h7FFF;
          4: s = 16'h0001;
          5: s = 16'hFFFE;
          default: s = 16'(j * 40503 + cfg * 977) ^ 16'(j << 3);
        endcase
        step((j % 5) != 4, s, (j % 7) == 3);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule